// File: doc/BRIEF.md
# DTMF Digit Validator and Encoder

This block sits behind a bank of eight tone detectors. Each millisecond tick it reads one presence flag for each of the four row frequencies and each of the four column frequencies. It decides whether a legal tone pair is present and measures how long that pair lasts. A pair that holds long enough is accepted as a digit. An accepted digit is latched into an output register and announced on a data-valid flag. The flag then stays up until the line has been silent long enough to count as a pause, or until the host clears it.

The stored digit is presented as a 4-bit code on three-state data lines. The code is either the hexadecimal digit code or a row/column pair, and it is driven only while the output enable is high. Pairs that use the fourth column can be inhibited, which reduces the alphabet to 12 keys. An early-detect flag rises part way through qualification and gives the host an advance warning. It falls shortly after the tones go away.

All thresholds are counted in ticks. The defaults place the accept and pause thresholds at 30 ticks: pairs of 40 ms or more are accepted, pairs of 20 ms or less are rejected, and gaps are treated the same way.

Top module: `dtmf_validator`

## Requirements
- R1: A pair is present only when exactly one row flag and exactly one column flag are set. Any other flag pattern is treated as silence and can neither produce a digit nor raise early detect.
- R2: A digit is accepted when the same pair is present for TONE_QUAL consecutive ticks. A pair that lasts TONE_QUAL-1 ticks or less is rejected. Cycles without a tick do not advance any duration.
- R3: When the pair changes before it is accepted, its duration restarts at one tick for the new pair.
- R4: After an accept, no further digit is accepted until a gap of PAUSE_QUAL consecutive silent ticks has been seen. That gap also clears valid_o. A shorter gap has no effect.
- R5: The digit register loads on the cycle after the accepting tick, and valid_o rises one cycle after that. The register holds its value until the next accepted digit. Reset leaves valid_o and early_o low.
- R6: A high on clr_valid_i clears valid_o on the next edge and leaves the stored digit unchanged. This does not re-arm acceptance, so the same tone resumed after a short gap is not reported again.
- R7: With hex_fmt_i=1, the code is as follows. Keys 1..9 give their binary value. Key 0 gives 1010, * gives 1011 and # gives 1100. The fourth-column keys in rows 0..3 give 1101, 1110, 1111 and 0000.
- R8: With hex_fmt_i=0, the code is {row index, column index}, with the row index in bits 3:2 and the column index in bits 1:0. The row index runs 0..3 for 697/770/852/941 Hz, on row_i bits 0..3. The column index runs 0..3 for 1209/1336/1477/1633 Hz, on col_i bits 0..3. The format is applied live to the stored digit.
- R9: While inhibit_c4_i is high, a pair with col_i[3] set is treated as silence.
- R10: data_o is driven only while oe_i is high and is high impedance otherwise.
- R11: early_o rises on the tick where the pair has lasted EARLY_ON ticks, which is before valid_o rises. It falls on the EARLY_OFF-th consecutive silent tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timing tick (one per millisecond) |
| row_i | input | 4 | Row tone flags, bit 0 = 697 Hz .. bit 3 = 941 Hz |
| col_i | input | 4 | Column tone flags, bit 0 = 1209 Hz .. bit 3 = 1633 Hz |
| hex_fmt_i | input | 1 | 1: hexadecimal code, 0: row/column code |
| inhibit_c4_i | input | 1 | Ignore pairs containing the 1633 Hz column |
| clr_valid_i | input | 1 | Host clear of valid_o |
| oe_i | input | 1 | Output enable for data_o |
| data_o | output | 4 | Three-state digit code |
| valid_o | output | 1 | Data valid |
| early_o | output | 1 | Early detect |

## Verification
The bench builds the block with TONE_QUAL=8, PAUSE_QUAL=8, EARLY_ON=3 and EARLY_OFF=2, and issues one tick every three clocks. The short windows keep every accept/reject boundary and pause boundary within a few dozen clocks, so both sides of each boundary are reached exactly. The idle clocks between ticks show that only ticks advance time. Because EARLY_ON and EARLY_OFF differ from the accept and pause counts, the rise and fall of the early flag can be told apart from the valid edges. Random key, format and duration draws then sweep all sixteen keys through both codings.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  typedef logic [1:0] idx_t;

  function automatic logic onehot4(input logic [3:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 4; i++) n += int'(v[i]);
    return n == 1;
  endfunction

  function automatic idx_t idx4(input logic [3:0] v);
    idx_t r;
    r = '0;
    for (int i = 0; i < 4; i++) if (v[i]) r = idx_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/dtmf_pair_decode.sv
module dtmf_pair_decode
  import dtmf_pkg::*;
(
  input  logic [3:0] row_i,
  input  logic [3:0] col_i,
  input  logic       inhibit_c4_i,
  output logic       vld_o,
  output idx_t       row_o,
  output idx_t       col_o
);
  logic legal;

  always_comb begin
    legal = onehot4(row_i) && onehot4(col_i);
    vld_o = legal && !(inhibit_c4_i && col_i[3]);
    row_o = idx4(row_i);
    col_o = idx4(col_i);
  end
endmodule

// File: rtl/dtmf_qualifier.sv
module dtmf_qualifier
  import dtmf_pkg::*;
#(
  parameter int unsigned TONE_QUAL  = 30,
  parameter int unsigned PAUSE_QUAL = 30,
  parameter int unsigned EARLY_ON   = 10,
  parameter int unsigned EARLY_OFF  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vld_i,
  input  idx_t row_i,
  input  idx_t col_i,
  output logic acc_o,
  output idx_t acc_row_o,
  output idx_t acc_col_o,
  output logic pause_o,
  output logic early_o
);
  localparam int unsigned TMAX_I = (TONE_QUAL > EARLY_ON) ? TONE_QUAL : EARLY_ON;
  localparam int unsigned GMAX_I = (PAUSE_QUAL > EARLY_OFF) ? PAUSE_QUAL : EARLY_OFF;
  localparam int unsigned MAXV   = (TMAX_I > GMAX_I) ? TMAX_I : GMAX_I;
  localparam int unsigned CW     = $clog2(MAXV + 1);
  localparam logic [CW-1:0] TMAX = CW'(TMAX_I);
  localparam logic [CW-1:0] GMAX = CW'(GMAX_I);
  localparam logic [CW-1:0] TQ   = CW'(TONE_QUAL);
  localparam logic [CW-1:0] PQ   = CW'(PAUSE_QUAL);
  localparam logic [CW-1:0] EON  = CW'(EARLY_ON);
  localparam logic [CW-1:0] EOFF = CW'(EARLY_OFF);

  logic [CW-1:0] tone_cnt_q, gap_cnt_q, tone_nx, gap_nx;
  idx_t          cand_row_q, cand_col_q;
  logic          locked_q, early_q, acc_q, pause_q;
  logic          same, acc_d, pause_d;

  always_comb begin
    same    = (row_i == cand_row_q) && (col_i == cand_col_q) && (tone_cnt_q != '0);
    tone_nx = !same ? CW'(1) : (tone_cnt_q == TMAX) ? TMAX : tone_cnt_q + CW'(1);
    gap_nx  = (gap_cnt_q == GMAX) ? GMAX : gap_cnt_q + CW'(1);
    acc_d   = tick_i && vld_i && !locked_q && (tone_nx == TQ);
    pause_d = tick_i && !vld_i && locked_q && (gap_nx == PQ);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tone_cnt_q <= '0;
      gap_cnt_q  <= '0;
      cand_row_q <= '0;
      cand_col_q <= '0;
      locked_q   <= 1'b0;
      early_q    <= 1'b0;
      acc_q      <= 1'b0;
      pause_q    <= 1'b0;
      acc_row_o  <= '0;
      acc_col_o  <= '0;
    end else begin
      acc_q   <= acc_d;
      pause_q <= pause_d;
      if (acc_d) begin
        acc_row_o <= row_i;
        acc_col_o <= col_i;
      end
      if (tick_i) begin
        if (vld_i) begin
          cand_row_q <= row_i;
          cand_col_q <= col_i;
          tone_cnt_q <= tone_nx;
          gap_cnt_q  <= '0;
          if (tone_nx >= EON) early_q <= 1'b1;
          if (acc_d) locked_q <= 1'b1;
        end else begin
          tone_cnt_q <= '0;
          gap_cnt_q  <= gap_nx;
          if (gap_nx >= EOFF) early_q <= 1'b0;
          if (pause_d) locked_q <= 1'b0;
        end
      end
    end
  end

  assign acc_o   = acc_q;
  assign pause_o = pause_q;
  assign early_o = early_q;

  // accept is a single pulse; acceptance locks until a pause
  p_acc_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> locked_q && !acc_d);
  // early detect is already up when a digit is accepted
  p_early_at_acc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> early_q);
  // a pause only follows silent ticks
  p_pause_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_q |-> tone_cnt_q == '0);
endmodule

// File: rtl/dtmf_code_enc.sv
module dtmf_code_enc
  import dtmf_pkg::*;
(
  input  idx_t       row_i,
  input  idx_t       col_i,
  input  logic       hex_fmt_i,
  output logic [3:0] code_o
);
  logic [3:0] hex;

  always_comb begin
    if (col_i == 2'd3) hex = 4'd13 + {2'b00, row_i};
    else if (row_i == 2'd3) begin
      unique case (col_i)
        2'd0:    hex = 4'd11;
        2'd1:    hex = 4'd10;
        default: hex = 4'd12;
      endcase
    end else hex = 4'({2'b00, row_i} * 4'd3 + {2'b00, col_i} + 4'd1);
    code_o = hex_fmt_i ? hex : {row_i, col_i};
  end
endmodule

// File: rtl/dtmf_validator.sv
module dtmf_validator
  import dtmf_pkg::*;
#(
  parameter int unsigned TONE_QUAL  = 30,
  parameter int unsigned PAUSE_QUAL = 30,
  parameter int unsigned EARLY_ON   = 10,
  parameter int unsigned EARLY_OFF  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [3:0] row_i,
  input  logic [3:0] col_i,
  input  logic       hex_fmt_i,
  input  logic       inhibit_c4_i,
  input  logic       clr_valid_i,
  input  logic       oe_i,
  output logic [3:0] data_o,
  output logic       valid_o,
  output logic       early_o
);
  logic       pair_vld, acc, pause, set_q, valid_q;
  idx_t       pair_row, pair_col, acc_row, acc_col, dig_row_q, dig_col_q;
  logic [3:0] code;

  dtmf_pair_decode u_dec (
    .row_i        (row_i),
    .col_i        (col_i),
    .inhibit_c4_i (inhibit_c4_i),
    .vld_o        (pair_vld),
    .row_o        (pair_row),
    .col_o        (pair_col)
  );

  dtmf_qualifier #(
    .TONE_QUAL  (TONE_QUAL),
    .PAUSE_QUAL (PAUSE_QUAL),
    .EARLY_ON   (EARLY_ON),
    .EARLY_OFF  (EARLY_OFF)
  ) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .vld_i     (pair_vld),
    .row_i     (pair_row),
    .col_i     (pair_col),
    .acc_o     (acc),
    .acc_row_o (acc_row),
    .acc_col_o (acc_col),
    .pause_o   (pause),
    .early_o   (early_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_row_q <= '0;
      dig_col_q <= '0;
      set_q     <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      set_q <= acc;
      if (acc) begin
        dig_row_q <= acc_row;
        dig_col_q <= acc_col;
      end
      if (set_q) valid_q <= 1'b1;
      else if (pause || clr_valid_i) valid_q <= 1'b0;
    end
  end

  dtmf_code_enc u_enc (
    .row_i     (dig_row_q),
    .col_i     (dig_col_q),
    .hex_fmt_i (hex_fmt_i),
    .code_o    (code)
  );

  assign data_o  = oe_i ? code : 4'bzzzz;
  assign valid_o = valid_q;

  // register loads while valid is low, then holds while valid is high
  p_load_while_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> !valid_q);
  p_data_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(valid_q) |-> $stable({dig_row_q, dig_col_q}));
  p_host_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_valid_i && !set_q |=> !valid_q);
  p_no_col3_inhibited_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> !($past(inhibit_c4_i) && acc_col == 2'd3));
endmodule

// File: tb/dtmf_validator_tb_top.sv
module dtmf_validator_tb_top;
  localparam int TQ = 8, PQ = 8, EON = 3, EOFF = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [3:0] row = '0, col = '0;
  logic hex = 1'b1, inh = 1'b0, clr = 1'b0, oe = 1'b1;
  wire  [3:0] bus;
  logic valid, early;
  int n_chk = 0, n_fail = 0;
  logic [3:0] last_code;
  logic [1:0] last_r, last_c;

  pullup (bus[0]);
  pullup (bus[1]);
  pullup (bus[2]);
  pullup (bus[3]);

  always #2.5 clk = ~clk;

  dtmf_validator #(.TONE_QUAL(TQ), .PAUSE_QUAL(PQ), .EARLY_ON(EON), .EARLY_OFF(EOFF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .row_i(row), .col_i(col),
    .hex_fmt_i(hex), .inhibit_c4_i(inh), .clr_valid_i(clr), .oe_i(oe),
    .data_o(bus), .valid_o(valid), .early_o(early)
  );

  function automatic logic [3:0] exp_code(input int r, input int c, input logic h);
    if (!h) return 4'((r << 2) | c);
    if (c == 3) return 4'(13 + r);
    if (r == 3) return (c == 0) ? 4'd11 : (c == 1) ? 4'd10 : 4'd12;
    return 4'(r * 3 + c + 1);
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pair(input int r, input int c);
    row = 4'(1 << r);
    col = 4'(1 << c);
  endtask

  task automatic quiet();
    row = '0;
    col = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // tone of n ticks, then silence, outputs settled
  task automatic burst(input int r, input int c, input int n);
    pair(r, c);
    ticks(n);
    quiet();
    settle();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset valid", {3'b0, valid}, 4'd0);
    chk("R11 reset early", {3'b0, early}, 4'd0);
    rst_n = 1'b1;
    settle();

    // R2 accept at exactly TQ ticks, R7 hex of key 5
    burst(1, 1, TQ);
    chk("R2 accept at threshold", {3'b0, valid}, 4'd1);
    chk("R7 hex key 5", bus, 4'd5);

    // R4 short gap then another pair: ignored
    ticks(PQ - 1);
    burst(2, 2, TQ);
    chk("R4 short gap keeps valid", {3'b0, valid}, 4'd1);
    chk("R4 short gap no new digit", bus, 4'd5);
    ticks(PQ);
    settle();
    chk("R4 pause clears valid", {3'b0, valid}, 4'd0);

    // R2 rejection one tick short
    burst(2, 0, TQ - 1);
    chk("R2 reject below threshold", {3'b0, valid}, 4'd0);
    chk("R5 register holds", bus, 4'd5);
    ticks(PQ);

    // R2 no tick, no progress
    pair(2, 1);
    repeat (60) @(negedge clk);
    chk("R2 idle clocks do not count", {3'b0, valid}, 4'd0);
    ticks(TQ);
    quiet();
    settle();
    chk("R2 accept after ticks", {3'b0, valid}, 4'd1);
    chk("R7 hex key 8", bus, 4'd8);
    ticks(PQ);

    // R3 pair change restarts duration
    pair(0, 0);
    ticks(TQ - 2);
    pair(0, 1);
    ticks(TQ - 1);
    chk("R3 restart after change", {3'b0, valid}, 4'd0);
    ticks(1);
    quiet();
    settle();
    chk("R3 new pair accepted", {3'b0, valid}, 4'd1);
    chk("R3 new pair code", bus, 4'd2);
    ticks(PQ);

    // R1 illegal flag patterns
    row = 4'b0011; col = 4'b0001;
    ticks(TQ);
    chk("R1 two rows no early", {3'b0, early}, 4'd0);
    row = 4'b0001; col = 4'b0000;
    ticks(TQ);
    quiet();
    settle();
    chk("R1 illegal patterns no digit", {3'b0, valid}, 4'd0);

    // R9 inhibit of fourth column
    inh = 1'b1;
    burst(0, 3, TQ);
    chk("R9 inhibited pair ignored", {3'b0, valid}, 4'd0);
    ticks(PQ);
    inh = 1'b0;
    burst(0, 3, TQ);
    chk("R9 allowed when not inhibited", {3'b0, valid}, 4'd1);
    chk("R7 hex key A", bus, 4'd13);
    ticks(PQ);
    burst(3, 3, TQ);
    chk("R7 hex key D", bus, 4'd0);

    // R8 live format change
    hex = 1'b0;
    @(negedge clk);
    chk("R8 row/col of D", bus, 4'b1111);

    // R6 host clear
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    chk("R6 clear drops valid", {3'b0, valid}, 4'd0);
    chk("R6 clear keeps data", bus, 4'b1111);
    ticks(3);
    burst(3, 3, TQ);
    chk("R6 no re-report after clear", {3'b0, valid}, 4'd0);

    // R10 three-state
    hex = 1'b1;
    oe = 1'b0;
    @(negedge clk);
    chk("R10 released when disabled", bus, 4'b1111);
    oe = 1'b1;
    @(negedge clk);
    chk("R10 driven when enabled", bus, 4'd0);
    ticks(PQ);

    // R11 early detect timing
    pair(1, 2);
    ticks(EON - 1);
    chk("R11 early not yet", {3'b0, early}, 4'd0);
    ticks(1);
    chk("R11 early up", {3'b0, early}, 4'd1);
    chk("R11 early before valid", {3'b0, valid}, 4'd0);
    ticks(TQ - EON);
    quiet();
    settle();
    chk("R11 digit after early", bus, 4'd6);
    ticks(EOFF - 1);
    chk("R11 early holds on short silence", {3'b0, early}, 4'd1);
    ticks(1);
    chk("R11 early falls", {3'b0, early}, 4'd0);
    ticks(PQ);
    last_code = 4'd6;
    last_r = 2'd1;
    last_c = 2'd2;

    // random keys, formats and durations
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 40; k++) begin
      int r, c, len;
      logic h, good;
      r = int'($urandom_range(0, 3));
      c = int'($urandom_range(0, 3));
      h = 1'($urandom_range(0, 1));
      good = 1'($urandom_range(0, 1));
      len = good ? int'($urandom_range(TQ, TQ + 6)) : int'($urandom_range(1, TQ - 1));
      hex = h;
      burst(r, c, len);
      if (good) begin
        last_r = 2'(r);
        last_c = 2'(c);
      end
      chk(good ? "R2 random accept" : "R2 random reject", {3'b0, valid}, {3'b0, good});
      chk(h ? "R7 random code" : "R8 random code", bus, exp_code(last_r, last_c, h));
      ticks(PQ);
      chk("R4 random pause", {3'b0, valid}, 4'd0);
    end

    report();
  end
endmodule